// File: doc/BRIEF.md
# Burst Serial Receiver to Memory

This block takes the demodulated bit stream of one radio burst, already aligned by an earlier sync stage, and samples it on the recovered data clock. The whole block runs on that clock, and the host register port is synchronous to it as well. Bits are packed into 4-bit nibbles, first bit in the most significant position. Each nibble is written through a memory write port into a shared data memory: first the 16 nibbles of the control field, then the 80 nibbles of the payload field.

The host loads a control-field start address before the burst. It may load a payload-field start address at any time, including while the control field is still arriving. The payload start register is double-buffered. The value pending when the control field completes becomes the payload base for this burst. A host write made later only takes effect for the next burst.

The first nibble of the control field is the header. Only this nibble is decoded. It sets a cipher flag, and while the rest of the control field arrives the flag also drives a cipher enable for that field. A one-cycle done pulse marks the end of the burst.

Top module: `brx_burst_rx`

## Requirements
- R1: After reset, `mem_we`, `done`, `cipher_on` and `a_cipher_en` are 0.
- R2: Each nibble is formed from four consecutive received bits. The first of them is placed in bit 3 of `mem_wdata` and the last in bit 0. `mem_we` is high for exactly one cycle: the cycle after the edge that samples the fourth bit.
- R3: Control-field nibble k (k = 0..15) is written to address (A start + k) mod 2^AW. A start is the value the host held in the A start register (`host_sel`=0) before the `slot_start` edge.
- R4: Payload nibble j (j = 0..79) is written to (B base + j) mod 2^AW. B base is the B start register value (`host_sel`=1) held before the edge that samples the last control-field bit. A host write made earlier during the control field is therefore used in the same burst.
- R5: A host write to the B start register made after the control field has completed does not change the addresses of the current burst. It becomes the payload base of the next burst.
- R6: A burst produces exactly 96 writes, and `mem_we` stays 0 outside a burst.
- R7: `done` is a single-cycle pulse in the cycle after the final payload write.
- R8: Let `hdr` be the header nibble (the first four bits, first bit at bit 3). `cipher_on` becomes 1 after the edge that samples the fourth bit if `hdr[3:1]` equals 3'b011, and 0 otherwise. It is cleared by `slot_start` and otherwise holds, also after the burst.
- R9: `a_cipher_en` is 1 exactly while `cipher_on` is 1 and fewer than 64 bits of the current burst have been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered data clock, one edge per bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_start | input | 1 | High in the cycle of the first control-field bit |
| rx_bit | input | 1 | Serial received data |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects A start, 1 selects B start |
| host_data | input | AW | Start address written by the host |
| mem_we | output | 1 | Memory write strobe, one per nibble |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 4 | Nibble to store |
| cipher_on | output | 1 | Header requests ciphering |
| a_cipher_en | output | 1 | Ciphering active on the control field |
| done | output | 1 | Burst complete pulse |

## Verification
The sample after the edge that takes bit i (bit 0 arrives with `slot_start`) is where that edge's results show. When i mod 4 is 3, that sample carries the write for the nibble ending at bit i. After i = 3 it also carries the new `cipher_on`. `a_cipher_en` drops in the sample after i = 63. `done` appears one edge after the final write at i = 383. The bench drives each bit on the falling edge and checks every output 1 ns after the next rising edge against a model indexed by i. It sweeps all 16 header codes and places host writes of the B start register both inside and after the control field.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;

  function automatic logic hdr_match(nib_t nib, nib_t mask, nib_t code);
    return (nib & mask) == (code & mask);
  endfunction

  function automatic int burst_bits(int a_nibs, int b_nibs);
    return (a_nibs + b_nibs) * NIB_W;
  endfunction
endpackage

// File: rtl/brx_bit_packer.sv
module brx_bit_packer
  import brx_pkg::*;
(
  input  logic rx_clk,
  input  logic rst_n,
  input  logic take,
  input  logic nib_end,
  input  logic rx_bit,
  output nib_t nib_full,
  output logic mem_we,
  output nib_t mem_wdata
);
  logic [NIB_W-2:0] sr;

  assign nib_full = {sr, rx_bit};

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= nib_end;
      if (take) sr <= nib_full[NIB_W-2:0];
      if (nib_end) mem_wdata <= nib_full;
    end
  end

  assert_we_single_R2: assert property (@(posedge rx_clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  assert_we_needs_bit_R6: assert property (@(posedge rx_clk) disable iff (!rst_n)
    mem_we |-> $past(take));
endmodule

// File: rtl/brx_addr_seq.sv
module brx_addr_seq #(
  parameter int AW = 9
) (
  input  logic          rx_clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [AW-1:0] host_data,
  input  logic          slot_start,
  input  logic          nib_end,
  input  logic          last_a,
  output logic [AW-1:0] mem_addr
);
  logic [AW-1:0] a_start_q;
  logic [AW-1:0] b_pend_q;
  logic [AW-1:0] ptr;

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      a_start_q <= '0;
      b_pend_q  <= '0;
      ptr       <= '0;
      mem_addr  <= '0;
    end else begin
      if (host_we && !host_sel) a_start_q <= host_data;
      if (host_we && host_sel)  b_pend_q  <= host_data;
      if (slot_start) begin
        ptr <= a_start_q;
      end else if (nib_end) begin
        mem_addr <= ptr;
        ptr      <= last_a ? b_pend_q : ptr + AW'(1);
      end
    end
  end

  assert_ptr_load_R3: assert property (@(posedge rx_clk) disable iff (!rst_n)
    slot_start |=> ptr == $past(a_start_q));
  assert_b_switch_R4: assert property (@(posedge rx_clk) disable iff (!rst_n)
    last_a |=> ptr == $past(b_pend_q));
  assert_ptr_ignores_host_R5: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (!slot_start && !nib_end) |=> $stable(ptr));
endmodule

// File: rtl/brx_hdr_decode.sv
module brx_hdr_decode
  import brx_pkg::*;
#(
  parameter nib_t HDR_MASK = 4'b1110,
  parameter nib_t HDR_CODE = 4'b0110
) (
  input  logic rx_clk,
  input  logic rst_n,
  input  logic slot_start,
  input  logic hdr_strobe,
  input  nib_t nib,
  output logic cipher_on
);
  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n)          cipher_on <= 1'b0;
    else if (slot_start) cipher_on <= 1'b0;
    else if (hdr_strobe) cipher_on <= hdr_match(nib, HDR_MASK, HDR_CODE);
  end
endmodule

// File: rtl/brx_burst_rx.sv
module brx_burst_rx
  import brx_pkg::*;
#(
  parameter int   AW       = 9,
  parameter int   A_NIBS   = 16,
  parameter int   B_NIBS   = 80,
  parameter nib_t HDR_MASK = 4'b1110,
  parameter nib_t HDR_CODE = 4'b0110
) (
  input  logic          rx_clk,
  input  logic          rst_n,
  input  logic          slot_start,
  input  logic          rx_bit,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [AW-1:0] host_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_wdata,
  output logic          cipher_on,
  output logic          a_cipher_en,
  output logic          done
);
  localparam int A_BITS   = A_NIBS * NIB_W;
  localparam int TOT_BITS = burst_bits(A_NIBS, B_NIBS);
  localparam int CW       = $clog2(TOT_BITS + 1);

  logic          busy;
  logic [CW-1:0] bit_idx;
  logic [CW-1:0] cur_idx;
  logic          take, nib_end, hdr_strobe, last_a, last_b;
  logic          last_we_q;
  nib_t          nib_full;

  assign take       = slot_start | busy;
  assign cur_idx    = slot_start ? '0 : bit_idx;
  assign nib_end    = take && ((cur_idx % CW'(NIB_W)) == CW'(NIB_W - 1));
  assign hdr_strobe = nib_end && (cur_idx == CW'(NIB_W - 1));
  assign last_a     = nib_end && (cur_idx == CW'(A_BITS - 1));
  assign last_b     = nib_end && (cur_idx == CW'(TOT_BITS - 1));

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bit_idx   <= '0;
      last_we_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      last_we_q <= last_b;
      done      <= last_we_q;
      if (slot_start) begin
        busy    <= 1'b1;
        bit_idx <= CW'(1);
      end else if (busy) begin
        if (bit_idx == CW'(TOT_BITS - 1)) begin
          busy    <= 1'b0;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + CW'(1);
        end
      end
    end
  end

  assign a_cipher_en = cipher_on && busy && (bit_idx < CW'(A_BITS));

  brx_bit_packer u_pack (
    .rx_clk   (rx_clk),
    .rst_n    (rst_n),
    .take     (take),
    .nib_end  (nib_end),
    .rx_bit   (rx_bit),
    .nib_full (nib_full),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata)
  );

  brx_addr_seq #(.AW(AW)) u_addr (
    .rx_clk    (rx_clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_sel  (host_sel),
    .host_data (host_data),
    .slot_start(slot_start),
    .nib_end   (nib_end),
    .last_a    (last_a),
    .mem_addr  (mem_addr)
  );

  brx_hdr_decode #(.HDR_MASK(HDR_MASK), .HDR_CODE(HDR_CODE)) u_hdr (
    .rx_clk    (rx_clk),
    .rst_n     (rst_n),
    .slot_start(slot_start),
    .hdr_strobe(hdr_strobe),
    .nib       (nib_full),
    .cipher_on (cipher_on)
  );

  assert_done_after_we_R7: assert property (@(posedge rx_clk) disable iff (!rst_n)
    done |-> $past(mem_we));
  assert_done_single_R7: assert property (@(posedge rx_clk) disable iff (!rst_n)
    done |=> !done);
  assert_cipher_hold_R8: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (!slot_start && !hdr_strobe) |=> $stable(cipher_on));
  assert_cipher_clear_R8: assert property (@(posedge rx_clk) disable iff (!rst_n)
    slot_start |=> !cipher_on);
endmodule

// File: tb/brx_burst_rx_tb.sv
module brx_burst_rx_tb;
  localparam int AW   = 9;
  localparam int AMOD = 1 << AW;
  localparam int TOT  = 384;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_start = 1'b0, rx_bit = 1'b0;
  logic          host_we = 1'b0, host_sel = 1'b0;
  logic [AW-1:0] host_data = '0;
  logic          mem_we, cipher_on, a_cipher_en, done;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_wdata;

  int errors = 0, checks = 0;
  int pend = 0;
  logic bits [TOT];

  always #5 clk = ~clk;

  brx_burst_rx u_dut (
    .rx_clk(clk), .rst_n(rst_n), .slot_start(slot_start), .rx_bit(rx_bit),
    .host_we(host_we), .host_sel(host_sel), .host_data(host_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cipher_on(cipher_on), .a_cipher_en(a_cipher_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic gen_bit(int seed, logic [3:0] hdr, int i);
    int v;
    if (i < 4) return hdr[3-i];
    v = (i * 13 + seed) ^ (i >> 2) ^ (seed >> 1);
    return v[0];
  endfunction

  task automatic host_write(input logic sel, input int val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_data = AW'(val);
    @(negedge clk);
    host_we = 1'b0;
    if (sel) pend = val % AMOD;
  endtask

  // wpos: bit index at whose edge a B-start write lands (-1 for none)
  task automatic run_burst(input int a, input int wpos, input int wval,
                           input logic [3:0] hdr, input int seed);
    int  bbase, nwr;
    bit  match;
    int  k, ea, ed;
    match = (hdr[3:1] == 3'b011);
    bbase = (wpos >= 0 && wpos < 63) ? wval % AMOD : pend;
    nwr = 0;
    for (int i = 0; i < TOT; i++) bits[i] = gen_bit(seed, hdr, i);
    for (int i = 0; i < TOT + 3; i++) begin
      @(negedge clk);
      slot_start = (i == 0);
      rx_bit     = (i < TOT) ? bits[i] : 1'b0;
      host_we    = (i == wpos);
      host_sel   = 1'b1;
      host_data  = AW'(wval);
      @(posedge clk);
      #1;
      if (mem_we) nwr++;
      if (i < TOT && (i % 4) == 3) begin
        chk(mem_we == 1'b1, "R2 write strobe", int'(mem_we), 1);
        k  = i / 4;
        ed = {bits[i-3], bits[i-2], bits[i-1], bits[i]};
        chk(mem_wdata == 4'(ed), "R2 nibble data", int'(mem_wdata), ed);
        if (k < 16) begin
          ea = (a + k) % AMOD;
          chk(int'(mem_addr) == ea, "R3 A-field address", int'(mem_addr), ea);
        end else begin
          ea = (bbase + k - 16) % AMOD;
          chk(int'(mem_addr) == ea, "R4/R5 B-field address", int'(mem_addr), ea);
        end
      end else begin
        chk(mem_we == 1'b0, "R2/R6 no write", int'(mem_we), 0);
      end
      chk(done == (i == TOT), "R7 done timing", int'(done), int'(i == TOT));
      chk(cipher_on == (match && i >= 3), "R8 cipher flag",
          int'(cipher_on), int'(match && i >= 3));
      chk(a_cipher_en == (match && i >= 3 && i < 63), "R9 A-field cipher enable",
          int'(a_cipher_en), int'(match && i >= 3 && i < 63));
    end
    host_we = 1'b0;
    chk(nwr == 96, "R6 write count", nwr, 96);
    if (wpos >= 0) pend = wval % AMOD;
  endtask

  initial begin
    #1;
    chk(mem_we == 0 && done == 0 && cipher_on == 0 && a_cipher_en == 0,
        "R1 reset outputs", int'({mem_we, done, cipher_on, a_cipher_en}), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(mem_we == 0 && done == 0 && cipher_on == 0 && a_cipher_en == 0,
        "R1 outputs after reset release", int'({mem_we, done, cipher_on, a_cipher_en}), 0);

    host_write(1'b0, 'h010);
    host_write(1'b1, 'h040);
    run_burst('h010, -1, 0, 4'b0110, 3);

    host_write(1'b0, 'h005);
    host_write(1'b1, 'h030);
    run_burst('h005, 20, 'h080, 4'b1110, 11);   // R4: write during A-field

    host_write(1'b0, 'h1F0);
    run_burst('h1F0, 200, 'h120, 4'b0111, 17);  // R5: write during B-field

    host_write(1'b0, 'h1A0);
    run_burst('h1A0, -1, 0, 4'b0000, 23);       // R5: next burst uses 'h120

    for (int h = 0; h < 16; h++) begin
      host_write(1'b0, (h * 29 + 7) % AMOD);
      host_write(1'b1, (h * 53 + 300) % AMOD);
      run_burst((h * 29 + 7) % AMOD, -1, 0, 4'(h), h * 5 + 1);
      repeat (2) @(negedge clk);
      chk(cipher_on == (h[3:1] == 3'b011), "R8 flag held after burst",
          int'(cipher_on), int'(h[3:1] == 3'b011));
      chk(mem_we == 0, "R6 idle no write", int'(mem_we), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule